// File: doc/BRIEF.md
# Dual-Bank Serial LED Channel Driver Front End

This block is the digital front end of a 24-channel constant-current LED driver. A host streams bits over a slow serial pair (data plus shift clock), and a bank-select line steers each bit into one of two shift chains. One chain carries a 6-bit dot-correction value for every channel. The other carries an 8-bit brightness value for every channel. The bit pushed out of the top of the chain in use is presented on a cascade output, so several drivers can be daisy-chained.

When the latch strobe falls, every channel captures the product of its two bank values as a 14-bit level. The levels reach the outputs only while the output-reset line is high and the output-enable line is low. Otherwise every output is zero, and the stored chains and levels are left untouched. The serial inputs are sampled by a fast system clock through two-flop synchronizers. Each shift-clock rise and each latch fall is acted on exactly once. The PWM or current stage that consumes the levels is outside this block.

Top module: `dual_bank_led_front`

## Requirements
- R1: After the power-on reset (`rst_n` low), both shift chains, all latched levels, `serOut` and `chLevels` are zero.
- R2: On a rising edge of `shiftClk`, `serIn` enters bit 0 of the chain picked by `bankSel` and every other bit of that chain moves up one place. `bankSel` = 0 selects the 144-bit dot-correction chain and 1 selects the 192-bit brightness chain. The chain that is not selected does not change.
- R3: On the same rising edge, `serOut` takes the top bit of the selected chain as it was before the shift (bit 143 or bit 191). A bit entered on `serIn` therefore appears on `serOut` 144 or 192 shifts later.
- R4: Channel n takes its dot-correction value from bits 6n+5..6n of the first chain and its brightness value from bits 8n+7..8n of the second. Its level is their unsigned product, up to 63*255 = 16065.
- R5: A falling edge of `latchN` loads every channel's level with its product. A rising edge of `latchN`, or chain activity while `latchN` is held, leaves the levels unchanged.
- R6: `chLevels` shows the latched levels only while `outResetN` = 1 and `outEnN` = 0, and is all zero otherwise. The gating follows any change of either line and every latch.
- R7: Pulling `outResetN` low blanks the outputs only: the chains keep shifting, latches still load, and the latched values reappear when it returns high.
- R8: A `shiftClk` held high for many system clocks causes exactly one shift, and a held-low `latchN` causes exactly one load.
- R9: `chLevels` is a flat bus of 24 fields of 14 bits, with channel n in bits 14n+13..14n (channel 0 least significant).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples all serial inputs |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| serIn | input | 1 | Serial data bit |
| shiftClk | input | 1 | Serial shift clock, acts on its rising edge |
| bankSel | input | 1 | Chain select: 0 dot-correction, 1 brightness |
| latchN | input | 1 | Latch strobe, acts on its falling edge |
| outResetN | input | 1 | Output reset, active low, blanks outputs only |
| outEnN | input | 1 | Output enable, active low |
| serOut | output | 1 | Cascade bit taken from the top of the selected chain |
| chLevels | output | 336 | 24 latched channel levels of 14 bits, channel 0 in the LSBs |

## Verification
The bench builds the block with its default parameters: 24 channels, 6-bit and 8-bit fields, and two synchronizer stages. At these values the full 144- and 192-shift cascade latencies of both chains are measured bit by bit, and the product corner 63*255 sits in channel 0. A reference model of both chains and all levels predicts every output. The bench holds the shift clock high for many cycles, toggles the latch while chains change, and latches while outputs are blanked. This exposes repeated edges, wrong edge polarity and gating that wipes stored state.

// File: rtl/ledfront_pkg.sv
package ledfront_pkg;

  // Strobes handed from the control half to the datapath, one system clock wide
  typedef struct packed {
    logic shiftEn;   // synchronized rising edge of the shift clock
    logic bankSel;   // chain chosen for this shift
    logic serBit;    // bit to enter at position 0
    logic latchStb;  // synchronized falling edge of the latch strobe
    logic gateOn;    // outputs may show levels
  } strobe_t;

endpackage

// File: rtl/ledfront_ctrl.sv
module ledfront_ctrl
  import ledfront_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serIn,
  input  logic    shiftClk,
  input  logic    bankSel,
  input  logic    latchN,
  input  logic    outResetN,
  input  logic    outEnN,
  output strobe_t stb
);

  localparam int NUM_IN  = 6;
  localparam int I_SIN   = 0;
  localparam int I_DCK   = 1;
  localparam int I_SEL   = 2;
  localparam int I_LAT   = 3;
  localparam int I_RST   = 4;
  localparam int I_EN    = 5;
  localparam int LAST    = SYNC_STAGES - 1;
  // latch strobe idles high so no false falling edge leaves reset
  localparam logic [NUM_IN-1:0] IDLE_VEC = NUM_IN'(1) << I_LAT;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncQ [SYNC_STAGES];
  logic              dckPrev;
  logic              latPrev;
  logic [NUM_IN-1:0] syncd;

  assign rawIn = {outEnN, outResetN, latchN, bankSel, shiftClk, serIn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= IDLE_VEC;
      dckPrev <= 1'b0;
      latPrev <= 1'b1;
    end else begin
      syncQ[0] <= rawIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      dckPrev <= syncQ[LAST][I_DCK];
      latPrev <= syncQ[LAST][I_LAT];
    end
  end

  assign syncd = syncQ[LAST];

  always_comb begin
    stb.shiftEn  = syncd[I_DCK] & ~dckPrev;
    stb.latchStb = ~syncd[I_LAT] & latPrev;
    stb.bankSel  = syncd[I_SEL];
    stb.serBit   = syncd[I_SIN];
    stb.gateOn   = syncd[I_RST] & ~syncd[I_EN];
  end

  // R8: a held shift clock or latch level yields a single strobe
  a_r8_single_shift: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shiftEn |=> !stb.shiftEn);
  a_r8_single_latch: assert property (@(posedge clk) disable iff (!rst_n)
    stb.latchStb |=> !stb.latchStb);

endmodule

// File: rtl/ledfront_dpath.sv
module ledfront_dpath
  import ledfront_pkg::*;
#(
  parameter int NUM_CH  = 24,
  parameter int DC_BITS = 6,
  parameter int BR_BITS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  strobe_t                          stb,
  output logic                             serOut,
  output logic [NUM_CH*(DC_BITS+BR_BITS)-1:0] chLevels
);

  localparam int LVL_BITS = DC_BITS + BR_BITS;
  localparam int DC_LEN   = NUM_CH * DC_BITS;
  localparam int BR_LEN   = NUM_CH * BR_BITS;
  localparam int BUS_W    = NUM_CH * LVL_BITS;

  logic [DC_LEN-1:0] dcChain;
  logic [BR_LEN-1:0] brChain;
  logic [BUS_W-1:0]  latched;
  logic [BUS_W-1:0]  prodNext;
  logic [BUS_W-1:0]  levelNext;

  // Serial chains and cascade bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcChain <= '0;
      brChain <= '0;
      serOut  <= 1'b0;
    end else if (stb.shiftEn) begin
      if (stb.bankSel) begin
        serOut  <= brChain[BR_LEN-1];
        brChain <= {brChain[BR_LEN-2:0], stb.serBit};
      end else begin
        serOut  <= dcChain[DC_LEN-1];
        dcChain <= {dcChain[DC_LEN-2:0], stb.serBit};
      end
    end
  end

  // One multiplier per channel
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    assign prodNext[n*LVL_BITS +: LVL_BITS] =
      LVL_BITS'(dcChain[n*DC_BITS +: DC_BITS]) *
      LVL_BITS'(brChain[n*BR_BITS +: BR_BITS]);
  end

  assign levelNext = stb.latchStb ? prodNext : latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= '0;
      chLevels <= '0;
    end else begin
      latched  <= levelNext;
      chLevels <= stb.gateOn ? levelNext : '0;
    end
  end

  // R2: the unselected chain holds still
  a_r2_dc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.shiftEn && stb.bankSel) |=> $stable(dcChain));
  a_r2_br_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.shiftEn && !stb.bankSel) |=> $stable(brChain));
  // R3: the cascade bit only moves on a shift
  a_r3_sout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.shiftEn |=> $stable(serOut));
  // R5: levels only load on a latch strobe
  a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.latchStb |=> $stable(latched));
  // R6: closed gate means dark outputs
  a_r6_gate_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.gateOn |=> (chLevels == '0));

endmodule

// File: rtl/dual_bank_led_front.sv
module dual_bank_led_front
  import ledfront_pkg::*;
#(
  parameter int NUM_CH      = 24,
  parameter int DC_BITS     = 6,
  parameter int BR_BITS     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                serIn,
  input  logic                                shiftClk,
  input  logic                                bankSel,
  input  logic                                latchN,
  input  logic                                outResetN,
  input  logic                                outEnN,
  output logic                                serOut,
  output logic [NUM_CH*(DC_BITS+BR_BITS)-1:0] chLevels
);

  strobe_t stb;

  ledfront_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .serIn     (serIn),
    .shiftClk  (shiftClk),
    .bankSel   (bankSel),
    .latchN    (latchN),
    .outResetN (outResetN),
    .outEnN    (outEnN),
    .stb       (stb)
  );

  ledfront_dpath #(
    .NUM_CH  (NUM_CH),
    .DC_BITS (DC_BITS),
    .BR_BITS (BR_BITS)
  ) i_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .serOut   (serOut),
    .chLevels (chLevels)
  );

endmodule

// File: tb/test_dual_bank_led_front.sv
module test_dual_bank_led_front;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 24;
  localparam int DCB   = 6;
  localparam int BRB   = 8;
  localparam int LVL   = DCB + BRB;
  localparam int DCLEN = NCH * DCB;
  localparam int BRLEN = NCH * BRB;
  localparam int BUSW  = NCH * LVL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serIn = 1'b0, shiftClk = 1'b0, bankSel = 1'b0;
  logic latchN = 1'b1, outResetN = 1'b1, outEnN = 1'b0;
  logic serOut;
  logic [BUSW-1:0] chLevels;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_led_front i_dual_bank_led_front (
    .clk(clk), .rst_n(rst_n), .serIn(serIn), .shiftClk(shiftClk),
    .bankSel(bankSel), .latchN(latchN), .outResetN(outResetN),
    .outEnN(outEnN), .serOut(serOut), .chLevels(chLevels)
  );

  // reference model
  logic [DCLEN-1:0] mDc = '0;
  logic [BRLEN-1:0] mBr = '0;
  logic [LVL-1:0]   mLat [NCH];
  logic             mSout = 1'b0;
  logic             mRst = 1'b1, mEn = 1'b0;

  typedef struct {
    string           req;
    logic [BUSW-1:0] bus;
    logic            sout;
  } item_t;
  item_t sbq[$];

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  function automatic logic [BUSW-1:0] expBus();
    logic [BUSW-1:0] b;
    for (int n = 0; n < NCH; n++)
      b[n*LVL +: LVL] = (mRst && !mEn) ? mLat[n] : '0;
    return b;
  endfunction

  // driver side: push the prediction
  task automatic expectNow(input string req);
    item_t it;
    it.req = req; it.bus = expBus(); it.sout = mSout;
    sbq.push_back(it);
  endtask

  // monitor side: compare at falling edges
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        nChecks++;
        if (chLevels !== it.bus || serOut !== it.sout) begin
          nFails++;
          $display("FAIL %s: levels=%h sout=%b expected levels=%h sout=%b",
                   it.req, chLevels, serOut, it.bus, it.sout);
        end
      end
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(input logic bank, input logic b, input int highCycles);
    @(negedge clk);
    bankSel = bank; serIn = b;
    waitN(2);
    shiftClk = 1'b1;
    if (bank) begin
      mSout = mBr[BRLEN-1]; mBr = {mBr[BRLEN-2:0], b};
    end else begin
      mSout = mDc[DCLEN-1]; mDc = {mDc[DCLEN-2:0], b};
    end
    waitN(highCycles);
    shiftClk = 1'b0;
    waitN(4);
  endtask

  function automatic logic [DCB-1:0] dcVal(input int n, input int seed);
    if (n == 0 && seed == 0) return '1;
    return DCB'(n * 5 + seed * 7 + 1);
  endfunction

  function automatic logic [BRB-1:0] brVal(input int n, input int seed);
    if (n == 0 && seed == 0) return '1;
    return BRB'(n * 37 + seed * 3 + 11);
  endfunction

  task automatic loadDc(input int seed);
    for (int p = DCLEN - 1; p >= 0; p--) begin
      logic [DCB-1:0] v;
      v = dcVal(p / DCB, seed);
      shiftBit(1'b0, v[p % DCB], 4);
    end
  endtask

  task automatic loadBr(input int seed);
    for (int p = BRLEN - 1; p >= 0; p--) begin
      logic [BRB-1:0] v;
      v = brVal(p / BRB, seed);
      shiftBit(1'b1, v[p % BRB], 4);
    end
  endtask

  task automatic latchLow();
    @(negedge clk);
    latchN = 1'b0;
    for (int n = 0; n < NCH; n++)
      mLat[n] = LVL'(mDc[n*DCB +: DCB]) * LVL'(mBr[n*BRB +: BRB]);
    waitN(5);
  endtask

  task automatic latchHigh();
    @(negedge clk);
    latchN = 1'b1;
    waitN(5);
  endtask

  task automatic setGate(input logic r, input logic e);
    @(negedge clk);
    outResetN = r; outEnN = e; mRst = r; mEn = e;
    waitN(5);
  endtask

  task automatic cascadeRun(input logic bank, input int len, input string req);
    for (int i = 0; i < len; i++) shiftBit(bank, 1'b0, 4);
    for (int i = 0; i < len; i++) begin
      shiftBit(bank, 1'b1, 4);
      expectNow(req);  // still the earlier zeros
    end
    shiftBit(bank, 1'b1, 4);
    expectNow(req);    // first one emerges
  endtask

  task automatic finishRun();
    waitN(3);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    for (int n = 0; n < NCH; n++) mLat[n] = '0;
    waitN(5);
    rst_n = 1'b1;
    waitN(6);
    expectNow("R1");
    latchLow();  expectNow("R1");  // zero chains give zero products
    latchHigh();

    // R4 / R9: load both chains, latch, check every field
    loadDc(0);
    loadBr(0);
    latchLow();  expectNow("R4 R9");
    latchHigh(); expectNow("R5");  // rising edge: no change

    // R2: refill only the brightness chain, dot correction must survive
    loadBr(1);
    latchLow();  expectNow("R2");
    latchHigh();

    // R5: chain changes while latch held low, then rising edge
    latchLow();
    loadDc(2);
    latchHigh(); expectNow("R5");
    latchLow();  expectNow("R5");
    latchHigh();

    // R6: gating combinations
    setGate(1'b1, 1'b1); expectNow("R6");
    setGate(1'b1, 1'b0); expectNow("R6");
    setGate(1'b0, 1'b0); expectNow("R6");
    setGate(1'b0, 1'b1); expectNow("R6");
    setGate(1'b1, 1'b0); expectNow("R6");

    // R7: blanked, yet shifting and latching continue
    setGate(1'b0, 1'b0);
    loadBr(3);
    latchLow();  latchHigh(); expectNow("R7");
    setGate(1'b1, 1'b0); expectNow("R7");

    // R8: long shift-clock high gives one shift only
    shiftBit(1'b0, 1'b1, 40);
    shiftBit(1'b1, 1'b1, 40);
    @(negedge clk); latchN = 1'b0;
    for (int n = 0; n < NCH; n++)
      mLat[n] = LVL'(mDc[n*DCB +: DCB]) * LVL'(mBr[n*BRB +: BRB]);
    waitN(40);
    expectNow("R8");
    latchHigh();

    // R3: cascade latency of both chains
    cascadeRun(1'b0, DCLEN, "R3");
    cascadeRun(1'b1, BRLEN, "R3");
    expectNow("R3");

    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, expected finish before limit");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule